// File: doc/BRIEF.md
# CAN Fault Confinement Error Counters

This block holds the two error counters that a CAN node keeps for fault confinement and derives the node's confinement state from them. The protocol engine drives single-cycle event pulses into it: a receive error with a small penalty, a receive error with a large penalty, a good reception, a transmit error and a good transmission. The block updates a 9-bit transmit count and an 8-bit receive count on the same clock edge. It then places the node in one of three states: error-active, error-passive or bus-off.

The receive count does not step down uniformly. A good reception lowers it by one. When the count is above 128, a good reception instead reloads it with 120. A transmit count above 255 puts the node in bus-off. In that state every counting event is ignored until the recovery sequencer, which lies outside this block, pulses a recovery request. The low byte of each counter is also brought out for register readback.

The controller is a three-state machine. Its states are `ST_ACTIVE`, `ST_PASSIVE` and `ST_BUSOFF`, and it has these transitions:
- *go_passive*: from `ST_ACTIVE` when either new count exceeds 127.
- *go_active*: from `ST_PASSIVE` when both new counts are 127 or less.
- *go_busoff*: from `ST_ACTIVE` or `ST_PASSIVE` when the new transmit count exceeds 255.
- *recover*: from `ST_BUSOFF` to `ST_ACTIVE` on a recovery request.

In every other case the state holds. The counters and the state are updated on the same edge, and the state is computed from the counters' next values.

Top module: `can_fault_conf`

## Requirements
- R1: While `rst_n` is low at a rising edge (synchronous reset), both counters become 0 and the node is error-active (`err_active`=1, `err_passive`=0, `bus_off`=0).
- R2: Outside bus-off, `rx_err_big` adds 8 and `rx_err_small` adds 1 to the receive count, saturating at 255. Precedence among the receive inputs is: `rx_err_big`, then `rx_err_small`, then `rx_ok`. Only the highest-precedence pulsed input acts in a cycle.
- R3: Outside bus-off, a lone `rx_ok` reloads the receive count with 120 when it is above 128. Otherwise `rx_ok` lowers the count by 1, and a count of 0 stays at 0.
- R4: Outside bus-off, `tx_err` adds 8 to the transmit count. A lone `tx_ok` subtracts 1, and a count of 0 stays at 0. When both pulse together, only `tx_err` acts.
- R5: Outside bus-off, the node is error-passive whenever the transmit count or the receive count is above 127.
- R6: When the transmit count goes above 255, the node enters bus-off on the same edge (`bus_off`=1, other flags 0).
- R7: While in bus-off without a recovery request, every event input is ignored: both counts hold and the node stays in bus-off.
- R8: A `recover` pulse in bus-off clears both counts to 0 and returns the node to error-active. A `recover` pulse outside bus-off has no effect.
- R9: Outside bus-off, the node is error-active exactly when both counts are 127 or less.
- R10: A transmit event and a receive event in the same cycle are each applied to their own counter. The state flags reflect both new values after that single edge.
- R11: `tec_low` equals bits 7:0 of `tec` and `rec_low` equals `rec` at all times.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| rx_err_small | input | 1 | Receive error pulse, small penalty |
| rx_err_big | input | 1 | Receive error pulse, large penalty |
| rx_ok | input | 1 | Successful reception pulse |
| tx_err | input | 1 | Transmit error pulse |
| tx_ok | input | 1 | Successful transmission pulse |
| recover | input | 1 | Bus-off recovery request pulse |
| tec | output | 9 | Transmit error count |
| rec | output | 8 | Receive error count |
| err_active | output | 1 | Node is error-active |
| err_passive | output | 1 | Node is error-passive |
| bus_off | output | 1 | Node is bus-off |
| tec_low | output | 8 | Low byte of transmit count for readback |
| rec_low | output | 8 | Receive count for readback |

## Verification
Two kinds of event can coincide in one cycle. A transmit event and a receive event can arrive together, and so can several pulses aimed at the same counter. The bench provokes both cases directly. It drives `tx_err` with `rx_err_big`, and it drives all three receive inputs at once. A behavioural model written with integers then judges, on every clock, that each counter moved by its own rule and that the state flags track the combined result after a single edge. Pulses during bus-off, and recovery requests given outside it, are also compared against that model.

// File: rtl/cfc_pkg.sv
package cfc_pkg;
    typedef enum logic [1:0] {
        ST_ACTIVE  = 2'd0,
        ST_PASSIVE = 2'd1,
        ST_BUSOFF  = 2'd2
    } fc_state_t;
endpackage

// File: rtl/cfc_tx_count.sv
module cfc_tx_count #(
    parameter int W    = 9,
    parameter int STEP = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         freeze,
    input  logic         clear,
    input  logic         err,
    input  logic         ok,
    output logic [W-1:0] cnt,
    output logic [W-1:0] cnt_nxt
);
    localparam logic [W-1:0] MAX_V  = '1;
    localparam logic [W-1:0] STEP_V = W'(STEP);

    always_comb begin
        cnt_nxt = cnt;
        if (clear) begin
            cnt_nxt = '0;
        end else if (!freeze) begin
            if (err) begin
                cnt_nxt = (cnt > MAX_V - STEP_V) ? MAX_V : cnt + STEP_V;
            end else if (ok && cnt != '0) begin
                cnt_nxt = cnt - 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) cnt <= '0;
        else        cnt <= cnt_nxt;
    end

    AST_TEC_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        (!freeze && !clear && ok && !err && cnt == '0) |=> cnt == '0); // R4
    AST_TEC_ERR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (!freeze && !clear && err && cnt <= MAX_V - STEP_V) |=> cnt == $past(cnt) + STEP_V); // R4
endmodule

// File: rtl/cfc_rx_count.sv
module cfc_rx_count #(
    parameter int W          = 8,
    parameter int BIG        = 8,
    parameter int SMALL      = 1,
    parameter int SNAP_ABOVE = 128,
    parameter int SNAP_TO    = 120
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         freeze,
    input  logic         clear,
    input  logic         err_big,
    input  logic         err_small,
    input  logic         ok,
    output logic [W-1:0] cnt,
    output logic [W-1:0] cnt_nxt
);
    localparam logic [W-1:0] MAX_V   = '1;
    localparam logic [W-1:0] BIG_V   = W'(BIG);
    localparam logic [W-1:0] SMALL_V = W'(SMALL);
    localparam logic [W-1:0] ABOVE_V = W'(SNAP_ABOVE);
    localparam logic [W-1:0] SNAP_V  = W'(SNAP_TO);

    always_comb begin
        cnt_nxt = cnt;
        if (clear) begin
            cnt_nxt = '0;
        end else if (!freeze) begin
            if (err_big) begin
                cnt_nxt = (cnt > MAX_V - BIG_V) ? MAX_V : cnt + BIG_V;
            end else if (err_small) begin
                cnt_nxt = (cnt > MAX_V - SMALL_V) ? MAX_V : cnt + SMALL_V;
            end else if (ok) begin
                if (cnt > ABOVE_V)     cnt_nxt = SNAP_V;
                else if (cnt != '0)    cnt_nxt = cnt - 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) cnt <= '0;
        else        cnt <= cnt_nxt;
    end

    AST_REC_SNAP: assert property (@(posedge clk) disable iff (!rst_n)
        (!freeze && !clear && ok && !err_big && !err_small && cnt > ABOVE_V) |=> cnt == SNAP_V); // R3
    AST_REC_NO_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        (!freeze && !clear && (err_big || err_small)) |=> cnt >= $past(cnt)); // R2
endmodule

// File: rtl/cfc_state_fsm.sv
module cfc_state_fsm
    import cfc_pkg::*;
#(
    parameter int TW            = 9,
    parameter int RW            = 8,
    parameter int PASSIVE_LIMIT = 127,
    parameter int BUSOFF_LIMIT  = 255
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          recover,
    input  logic [TW-1:0] tec_cur,
    input  logic [RW-1:0] rec_cur,
    input  logic [TW-1:0] tec_nxt,
    input  logic [RW-1:0] rec_nxt,
    output logic          err_active,
    output logic          err_passive,
    output logic          bus_off
);
    localparam logic [TW-1:0] T_PAS_V = TW'(PASSIVE_LIMIT);
    localparam logic [RW-1:0] R_PAS_V = RW'(PASSIVE_LIMIT);
    localparam logic [TW-1:0] T_OFF_V = TW'(BUSOFF_LIMIT);

    fc_state_t state_q, state_d;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_BUSOFF: begin
                if (recover) state_d = ST_ACTIVE;                   // recover
            end
            ST_ACTIVE, ST_PASSIVE: begin
                if (tec_nxt > T_OFF_V)
                    state_d = ST_BUSOFF;                            // go_busoff
                else if (tec_nxt > T_PAS_V || rec_nxt > R_PAS_V)
                    state_d = ST_PASSIVE;                           // go_passive
                else
                    state_d = ST_ACTIVE;                            // go_active
            end
            default: state_d = ST_ACTIVE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_ACTIVE;
        else        state_q <= state_d;
    end

    always_comb begin
        err_active  = 1'b0;
        err_passive = 1'b0;
        bus_off     = 1'b0;
        unique case (state_q)
            ST_ACTIVE:  err_active  = 1'b1;
            ST_PASSIVE: err_passive = 1'b1;
            ST_BUSOFF:  bus_off     = 1'b1;
            default:    err_active  = 1'b1;
        endcase
    end

    AST_PASSIVE_MEANS_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        err_passive |-> (tec_cur > T_PAS_V || rec_cur > R_PAS_V)); // R5
    AST_ACTIVE_MEANS_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        err_active |-> (tec_cur <= T_PAS_V && rec_cur <= R_PAS_V)); // R9
    AST_BUSOFF_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_off && !recover) |=> bus_off); // R7
    AST_RECOVER_ACTIVE: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_off && recover) |=> err_active); // R8
endmodule

// File: rtl/can_fault_conf.sv
module can_fault_conf #(
    parameter int TEC_W         = 9,
    parameter int REC_W         = 8,
    parameter int TX_ERR_STEP   = 8,
    parameter int RX_BIG_STEP   = 8,
    parameter int RX_SMALL_STEP = 1,
    parameter int SNAP_ABOVE    = 128,
    parameter int SNAP_TO       = 120,
    parameter int PASSIVE_LIMIT = 127,
    parameter int BUSOFF_LIMIT  = 255,
    parameter int LOW_W         = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             rx_err_small,
    input  logic             rx_err_big,
    input  logic             rx_ok,
    input  logic             tx_err,
    input  logic             tx_ok,
    input  logic             recover,
    output logic [TEC_W-1:0] tec,
    output logic [REC_W-1:0] rec,
    output logic             err_active,
    output logic             err_passive,
    output logic             bus_off,
    output logic [LOW_W-1:0] tec_low,
    output logic [LOW_W-1:0] rec_low
);
    logic [TEC_W-1:0] tec_nxt;
    logic [REC_W-1:0] rec_nxt;
    logic             do_clear;

    assign do_clear = bus_off & recover;

    cfc_tx_count #(.W(TEC_W), .STEP(TX_ERR_STEP)) u_tx (
        .clk(clk), .rst_n(rst_n), .freeze(bus_off), .clear(do_clear),
        .err(tx_err), .ok(tx_ok), .cnt(tec), .cnt_nxt(tec_nxt)
    );

    cfc_rx_count #(.W(REC_W), .BIG(RX_BIG_STEP), .SMALL(RX_SMALL_STEP),
                   .SNAP_ABOVE(SNAP_ABOVE), .SNAP_TO(SNAP_TO)) u_rx (
        .clk(clk), .rst_n(rst_n), .freeze(bus_off), .clear(do_clear),
        .err_big(rx_err_big), .err_small(rx_err_small), .ok(rx_ok),
        .cnt(rec), .cnt_nxt(rec_nxt)
    );

    cfc_state_fsm #(.TW(TEC_W), .RW(REC_W), .PASSIVE_LIMIT(PASSIVE_LIMIT),
                    .BUSOFF_LIMIT(BUSOFF_LIMIT)) u_fsm (
        .clk(clk), .rst_n(rst_n), .recover(recover),
        .tec_cur(tec), .rec_cur(rec), .tec_nxt(tec_nxt), .rec_nxt(rec_nxt),
        .err_active(err_active), .err_passive(err_passive), .bus_off(bus_off)
    );

    assign tec_low = tec[LOW_W-1:0];
    assign rec_low = LOW_W'(rec);

    AST_BUSOFF_FREEZE: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_off && !recover) |=> ($stable(tec) && $stable(rec))); // R7
    AST_RECOVER_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_off && recover) |=> (tec == '0 && rec == '0)); // R8
endmodule

// File: tb/can_fault_conf_tb_top.sv
`timescale 1ns/1ps
module can_fault_conf_tb_top;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic rx_err_small = 0, rx_err_big = 0, rx_ok = 0, tx_err = 0, tx_ok = 0, recover = 0;
    logic [8:0] tec;
    logic [7:0] rec, tec_low, rec_low;
    logic err_active, err_passive, bus_off;

    always #2 clk = ~clk; // 250 MHz

    can_fault_conf dut_i (
        .clk(clk), .rst_n(rst_n), .rx_err_small(rx_err_small), .rx_err_big(rx_err_big),
        .rx_ok(rx_ok), .tx_err(tx_err), .tx_ok(tx_ok), .recover(recover),
        .tec(tec), .rec(rec), .err_active(err_active), .err_passive(err_passive),
        .bus_off(bus_off), .tec_low(tec_low), .rec_low(rec_low)
    );

    int checks = 0;
    int failures = 0;
    string cur_req = "R1";

    // Behavioural reference: 0 active, 1 passive, 2 bus-off
    int m_tec = 0, m_rec = 0, m_st = 0;

    always @(posedge clk) begin
        if (!rst_n) begin
            m_tec = 0; m_rec = 0; m_st = 0;
        end else if (m_st == 2) begin
            if (recover) begin m_tec = 0; m_rec = 0; m_st = 0; end
        end else begin
            if (tx_err) m_tec = m_tec + 8;
            else if (tx_ok && m_tec > 0) m_tec = m_tec - 1;
            if (rx_err_big) m_rec = (m_rec + 8 > 255) ? 255 : m_rec + 8;
            else if (rx_err_small) m_rec = (m_rec + 1 > 255) ? 255 : m_rec + 1;
            else if (rx_ok) begin
                if (m_rec > 128) m_rec = 120;
                else if (m_rec > 0) m_rec = m_rec - 1;
            end
            if (m_tec > 255) m_st = 2;
            else if (m_tec > 127 || m_rec > 127) m_st = 1;
            else m_st = 0;
        end
    end

    task automatic chk(input string req, input int act, input int exp, input string what);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    // Per-clock comparison against the model
    always @(negedge clk) begin
        if (rst_n) begin
            chk(cur_req, int'(tec), m_tec, "tec");
            chk(cur_req, int'(rec), m_rec, "rec");
            chk("R11", int'(tec_low), m_tec % 256, "tec_low");
            chk("R11", int'(rec_low), m_rec, "rec_low");
            chk(cur_req, int'({bus_off, err_passive, err_active}),
                (m_st == 0) ? 1 : (m_st == 1) ? 2 : 4, "flags");
        end
    end

    // bits: {recover, tx_err, tx_ok, rx_err_big, rx_err_small, rx_ok}
    task automatic ev(input logic [5:0] v, input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            {recover, tx_err, tx_ok, rx_err_big, rx_err_small, rx_ok} = v;
        end
        @(negedge clk);
        {recover, tx_err, tx_ok, rx_err_big, rx_err_small, rx_ok} = '0;
    endtask

    task automatic expect_now(input string req, input int t, input int r, input int fl);
        @(negedge clk);
        chk(req, int'(tec), t, "tec direct");
        chk(req, int'(rec), r, "rec direct");
        chk(req, int'({bus_off, err_passive, err_active}), fl, "flags direct");
    endtask

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        failures++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        expect_now("R1", 0, 0, 1);

        cur_req = "R2";
        ev(6'b000010, 3);  expect_now("R2", 0, 3, 1);
        ev(6'b000100, 2);  expect_now("R2", 0, 19, 1);
        ev(6'b000111, 1);  expect_now("R2", 0, 27, 1);   // big wins
        ev(6'b000011, 1);  expect_now("R2", 0, 28, 1);   // small over ok
        ev(6'b000100, 40); expect_now("R2", 0, 255, 2);  // saturate, R5 passive
        ev(6'b000010, 2);  expect_now("R2", 0, 255, 2);

        cur_req = "R3";
        ev(6'b000001, 1);  expect_now("R3", 0, 120, 1);  // snap, R9 active
        ev(6'b000100, 1);  expect_now("R3", 0, 128, 2);
        ev(6'b000001, 1);  expect_now("R3", 0, 127, 1);  // 128 not snapped
        ev(6'b000010, 2);  expect_now("R3", 0, 129, 2);
        ev(6'b000001, 1);  expect_now("R3", 0, 120, 1);
        ev(6'b000001, 125); expect_now("R3", 0, 0, 1);   // floor

        cur_req = "R4";
        ev(6'b010000, 3);  expect_now("R4", 24, 0, 1);
        ev(6'b011000, 1);  expect_now("R4", 32, 0, 1);   // err wins
        ev(6'b001000, 40); expect_now("R4", 0, 0, 1);    // floor

        cur_req = "R10";
        ev(6'b010100, 16); expect_now("R10", 128, 128, 2);
        ev(6'b001001, 1);  expect_now("R10", 127, 127, 1);

        cur_req = "R5";
        ev(6'b010000, 1);  expect_now("R5", 135, 127, 2);
        cur_req = "R9";
        ev(6'b001000, 8);  expect_now("R9", 127, 127, 1);

        cur_req = "R8";
        ev(6'b100000, 2);  expect_now("R8", 127, 127, 1); // ignored outside bus-off

        cur_req = "R6";
        ev(6'b010000, 16); expect_now("R6", 255, 127, 2);
        ev(6'b010000, 1);  expect_now("R6", 263, 127, 4);

        cur_req = "R7";
        ev(6'b011111, 5);  expect_now("R7", 263, 127, 4);
        ev(6'b000100, 3);  expect_now("R7", 263, 127, 4);

        cur_req = "R8";
        ev(6'b100000, 1);  expect_now("R8", 0, 0, 1);
        ev(6'b010100, 2);  expect_now("R8", 16, 16, 1);

        cur_req = "R1";
        @(negedge clk); rst_n = 1'b0;
        @(negedge clk); rst_n = 1'b1;
        expect_now("R1", 0, 0, 1);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule